// File: doc/BRIEF.md
# Predictive Load-Miss Fetch Gate

This block sits beside the fetch stage of a multithreaded core and decides, for each thread, whether fetch should be held off because that thread already has data-cache misses in flight. When a load is fetched, the block looks up a table of small confidence counters indexed by the load's address and predicts whether the load will miss the first-level data cache. A predicted miss is counted against the thread right away. The thread does not have to wait for the execute stage to discover the miss, so fewer dependent instructions reach the issue queue before the thread is stopped.

The prediction flag travels down the pipeline with the load, outside this block. When the load's real cache outcome comes back, it is presented here with that flag. The block trains the table: a miss clears the entry and a hit strengthens it by one. If the load missed but was not counted at fetch, the block counts it now. When a counted load commits, its thread's count drops by one. A thread's fetch-gate output is high whenever its count is above a configurable limit. A mode input turns off counting at fetch, so that only misses found at execute are counted.

Top module: `ldmiss_fetch_gate`

## Requirements
- R1: After synchronous reset, every thread count is zero, every fetch-gate bit and every registered output is low, and every table entry holds 2'b10, so that every load is predicted to hit.
- R2: The table index is PC bits [IDX_LSB +: log2(PRED_ENTRIES)], which is bits [12:2] by default. Two PCs that differ only outside those bits share an entry.
- R3: A lookup (fe_valid and fe_is_load high) sets fe_pred_vld one cycle later, together with the request's thread id. At the same time fe_pred_miss is the inverse of the entry's most significant bit. When there is no lookup, all four registered fetch outputs are zero.
- R4: A resolve writes the entry for rs_pc. An actual miss (rs_miss=1) sets the entry to 2'b00. An actual hit adds one, and the entry stays at 2'b11 once it gets there.
- R5: When a lookup and a resolve address the same entry in the same cycle, the update is applied, but the lookup's prediction and count use the value the entry held before the update.
- R6: When pred_en is high, a predicted miss raises fe_pred_counted and increments the requesting thread's count at the same clock edge that produces the prediction.
- R7: A resolve raises rs_done one cycle later. It increments the thread's count only if rs_miss=1 and rs_fe_counted=0. rs_counted is set to rs_fe_counted OR rs_miss.
- R8: When pred_en is low, fetch never counts: fe_pred_counted stays 0, but fe_pred_miss still reports the prediction.
- R9: A commit with cm_counted=1 decrements its thread's count, and the count never goes below zero. A commit with cm_counted=0 leaves the count unchanged.
- R10: fetch_gate[t] is high exactly when thread t's count is greater than GATE_LIMIT, and it changes at the same edge as the count.
- R11: Events that reach one thread in the same cycle are combined: the count changes by (fetch increment + resolve increment − commit decrement), and the result saturates at 2^CNT_W − 1.
- R12: Each thread's count responds only to events that carry its own thread id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_en | input | 1 | 1: count predicted misses at fetch; 0: count only misses found at execute |
| fe_valid | input | 1 | Fetch slot valid |
| fe_is_load | input | 1 | Fetched instruction is a load |
| fe_tid | input | TID_W | Thread of the fetched load |
| fe_pc | input | PC_W | PC of the fetched load |
| fe_pred_vld | output | 1 | Prediction result valid (one cycle after the lookup) |
| fe_pred_tid | output | TID_W | Thread of the prediction |
| fe_pred_miss | output | 1 | 1 = miss predicted |
| fe_pred_counted | output | 1 | Load was counted at fetch; carried with the load |
| rs_valid | input | 1 | Load outcome valid |
| rs_tid | input | TID_W | Thread of the resolving load |
| rs_pc | input | PC_W | PC of the resolving load |
| rs_miss | input | 1 | 1 = load actually missed |
| rs_fe_counted | input | 1 | Counted-at-fetch flag carried with the load |
| rs_done | output | 1 | Resolve accepted (one cycle after rs_valid) |
| rs_counted | output | 1 | Load is now counted; carried to commit |
| cm_valid | input | 1 | Load commit valid |
| cm_tid | input | TID_W | Thread of the committing load |
| cm_counted | input | 1 | Committing load was counted |
| fetch_gate | output | NUM_THREADS | Per-thread fetch hold |

## Verification
The bench builds the block with its default parameters: four threads, a 2048-entry table indexed by PC bits [12:2], 6-bit counts and a gate limit of 0. With a limit of 0, one outstanding miss is enough to raise a thread's gate, so every change of a count between zero and non-zero is visible at the fetch_gate port. Random PCs are drawn from a small set of indexes, so the same entries are trained and looked up again and again, and a lookup and a resolve often hit one entry in the same cycle. Aliasing is exercised with a PC that differs from another only in bit 13 and bit 0.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  typedef logic [1:0] pctr_t;

  localparam pctr_t PCTR_INIT = 2'b10;

  // train rule: miss clears, hit increments with saturation
  function automatic pctr_t pctr_train(input pctr_t cur, input logic miss);
    if (miss) return 2'b00;
    return (cur == 2'b11) ? 2'b11 : cur + 2'b01;
  endfunction
endpackage

// File: rtl/ldg_pred_table.sv
module ldg_pred_table
  import ldg_pkg::*;
#(
  parameter int ENTRIES = 2048,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_miss,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_miss
);
  pctr_t tab [ENTRIES];

  // read returns the pre-write value, so a same-cycle update is not seen
  assign rd_miss = ~tab[rd_idx][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= PCTR_INIT;
    end else if (wr_en) begin
      tab[wr_idx] <= pctr_train(tab[wr_idx], wr_miss);
    end
  end

  // R4: an actual miss leaves the entry at zero
  a_r4_miss_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_miss) |=> tab[$past(wr_idx)] == 2'b00);
  // R4: an actual hit never leaves the entry at zero
  a_r4_hit_nonzero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_miss) |=> tab[$past(wr_idx)] != 2'b00);
endmodule

// File: rtl/ldg_thread_ctr.sv
module ldg_thread_ctr #(
  parameter int CNT_W      = 6,
  parameter int GATE_LIMIT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_fe,
  input  logic inc_rs,
  input  logic dec,
  output logic gate
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(GATE_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(cnt_q) + SUM_W'(inc_fe) + SUM_W'(inc_rs);
    if (dec && (sum != '0)) sum = sum - SUM_W'(1);
    cnt_d = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      gate  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      gate  <= (cnt_d > LIMIT);
    end
  end

  // R9: a decrement at zero with no increment keeps the count at zero
  a_r9_floor: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && dec && !inc_fe && !inc_rs) |=> cnt_q == '0);
  // R11: the count never grows by more than two per cycle
  a_r11_step_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> SUM_W'(cnt_q) <= SUM_W'($past(cnt_q)) + SUM_W'(2));
  // R10: the gate only rises after an increment
  a_r10_gate_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> $past(inc_fe || inc_rs));
endmodule

// File: rtl/ldmiss_fetch_gate.sv
module ldmiss_fetch_gate #(
  parameter int NUM_THREADS  = 4,
  parameter int PRED_ENTRIES = 2048,
  parameter int PC_W         = 32,
  parameter int IDX_LSB      = 2,
  parameter int CNT_W        = 6,
  parameter int GATE_LIMIT   = 0,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W = $clog2(PRED_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pred_en,
  input  logic                   fe_valid,
  input  logic                   fe_is_load,
  input  logic [TID_W-1:0]       fe_tid,
  input  logic [PC_W-1:0]        fe_pc,
  output logic                   fe_pred_vld,
  output logic [TID_W-1:0]       fe_pred_tid,
  output logic                   fe_pred_miss,
  output logic                   fe_pred_counted,
  input  logic                   rs_valid,
  input  logic [TID_W-1:0]       rs_tid,
  input  logic [PC_W-1:0]        rs_pc,
  input  logic                   rs_miss,
  input  logic                   rs_fe_counted,
  output logic                   rs_done,
  output logic                   rs_counted,
  input  logic                   cm_valid,
  input  logic [TID_W-1:0]       cm_tid,
  input  logic                   cm_counted,
  output logic [NUM_THREADS-1:0] fetch_gate
);
  logic             lookup;
  logic             lookup_miss;
  logic             fe_count;
  logic             rs_count;
  logic [IDX_W-1:0] fe_idx, rs_idx;
  logic             unused_pc_bits;

  assign lookup   = fe_valid && fe_is_load;
  assign fe_idx   = fe_pc[IDX_LSB +: IDX_W];
  assign rs_idx   = rs_pc[IDX_LSB +: IDX_W];
  assign fe_count = lookup && pred_en && lookup_miss;
  assign rs_count = rs_valid && rs_miss && !rs_fe_counted;
  assign unused_pc_bits = ^{fe_pc[PC_W-1:IDX_LSB+IDX_W], fe_pc[IDX_LSB-1:0],
                            rs_pc[PC_W-1:IDX_LSB+IDX_W], rs_pc[IDX_LSB-1:0]};

  ldg_pred_table #(.ENTRIES(PRED_ENTRIES)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (fe_idx),
    .rd_miss (lookup_miss),
    .wr_en   (rs_valid),
    .wr_idx  (rs_idx),
    .wr_miss (rs_miss)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic inc_fe_t, inc_rs_t, dec_t;
    assign inc_fe_t = fe_count && (fe_tid == TID_W'(t));
    assign inc_rs_t = rs_count && (rs_tid == TID_W'(t));
    assign dec_t    = cm_valid && cm_counted && (cm_tid == TID_W'(t));

    ldg_thread_ctr #(.CNT_W(CNT_W), .GATE_LIMIT(GATE_LIMIT)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .inc_fe (inc_fe_t),
      .inc_rs (inc_rs_t),
      .dec    (dec_t),
      .gate   (fetch_gate[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_pred_vld     <= 1'b0;
      fe_pred_tid     <= '0;
      fe_pred_miss    <= 1'b0;
      fe_pred_counted <= 1'b0;
      rs_done         <= 1'b0;
      rs_counted      <= 1'b0;
    end else begin
      fe_pred_vld     <= lookup;
      fe_pred_tid     <= lookup ? fe_tid : '0;
      fe_pred_miss    <= lookup && lookup_miss;
      fe_pred_counted <= fe_count;
      rs_done         <= rs_valid;
      rs_counted      <= rs_valid && (rs_fe_counted || rs_miss);
    end
  end

  // R3: every load lookup yields a valid prediction one cycle later
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
    (fe_valid && fe_is_load) |=> fe_pred_vld);
  // R6: a load counted at fetch always carries a miss prediction
  a_r6_counted_is_miss: assert property (@(posedge clk) disable iff (rst)
    fe_pred_counted |-> (fe_pred_miss && fe_pred_vld));
  // R8: with prediction off nothing is counted at fetch
  a_r8_off_no_count: assert property (@(posedge clk) disable iff (rst)
    (fe_valid && fe_is_load && !pred_en) |=> !fe_pred_counted);
  // R7: an actual miss always leaves the load counted
  a_r7_miss_counted: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_miss) |=> (rs_done && rs_counted));
endmodule

// File: tb/ldmiss_fetch_gate_tb.sv
module ldmiss_fetch_gate_tb;
  localparam int NT = 4;
  localparam int ENT = 2048;
  localparam int CMAX = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_en = 1'b1;
  logic fe_valid = 0, fe_is_load = 0;
  logic [1:0] fe_tid = 0;
  logic [31:0] fe_pc = 0;
  logic fe_pred_vld, fe_pred_miss, fe_pred_counted;
  logic [1:0] fe_pred_tid;
  logic rs_valid = 0, rs_miss = 0, rs_fe_counted = 0;
  logic [1:0] rs_tid = 0;
  logic [31:0] rs_pc = 0;
  logic rs_done, rs_counted;
  logic cm_valid = 0, cm_counted = 0;
  logic [1:0] cm_tid = 0;
  logic [NT-1:0] fetch_gate;

  always #5 clk = ~clk;

  ldmiss_fetch_gate u_dut (
    .clk(clk), .rst(rst), .pred_en(pred_en),
    .fe_valid(fe_valid), .fe_is_load(fe_is_load), .fe_tid(fe_tid), .fe_pc(fe_pc),
    .fe_pred_vld(fe_pred_vld), .fe_pred_tid(fe_pred_tid),
    .fe_pred_miss(fe_pred_miss), .fe_pred_counted(fe_pred_counted),
    .rs_valid(rs_valid), .rs_tid(rs_tid), .rs_pc(rs_pc), .rs_miss(rs_miss),
    .rs_fe_counted(rs_fe_counted), .rs_done(rs_done), .rs_counted(rs_counted),
    .cm_valid(cm_valid), .cm_tid(cm_tid), .cm_counted(cm_counted),
    .fetch_gate(fetch_gate)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] m_tab [ENT];
  int m_cnt [NT];
  logic e_pvld, e_pmiss, e_pcnt, e_rdone, e_rcnt;
  logic [1:0] e_ptid;
  logic [NT-1:0] e_gate;

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[12:2]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) m_tab[i] = 2'b10;
    for (int t = 0; t < NT; t++) m_cnt[t] = 0;
    {e_pvld, e_pmiss, e_pcnt, e_rdone, e_rcnt} = '0;
    e_ptid = 0; e_gate = '0;
  endtask

  task automatic model_update();
    int inc [NT];
    for (int t = 0; t < NT; t++) inc[t] = 0;
    e_pvld = fe_valid && fe_is_load;
    e_ptid = e_pvld ? fe_tid : 2'd0;
    e_pmiss = e_pvld && !m_tab[idx_of(fe_pc)][1];
    e_pcnt = e_pmiss && pred_en;
    if (e_pcnt) inc[fe_tid]++;
    e_rdone = rs_valid;
    e_rcnt = rs_valid && (rs_fe_counted || rs_miss);
    if (rs_valid) begin
      if (rs_miss) m_tab[idx_of(rs_pc)] = 2'b00;
      else if (m_tab[idx_of(rs_pc)] != 2'b11) m_tab[idx_of(rs_pc)] = m_tab[idx_of(rs_pc)] + 2'b01;
      if (rs_miss && !rs_fe_counted) inc[rs_tid]++;
    end
    for (int t = 0; t < NT; t++) begin
      int v;
      v = m_cnt[t] + inc[t];
      if (cm_valid && cm_counted && cm_tid == 2'(t) && v > 0) v--;
      if (v > CMAX) v = CMAX;
      m_cnt[t] = v;
      e_gate[t] = (v > 0);
    end
  endtask

  task automatic compare();
    chk("R3 pred_vld", int'(fe_pred_vld), int'(e_pvld));
    chk("R3 pred_tid", int'(fe_pred_tid), int'(e_ptid));
    chk("R3 pred_miss", int'(fe_pred_miss), int'(e_pmiss));
    chk("R6 pred_counted", int'(fe_pred_counted), int'(e_pcnt));
    chk("R7 rs_done", int'(rs_done), int'(e_rdone));
    chk("R7 rs_counted", int'(rs_counted), int'(e_rcnt));
    chk("R10 fetch_gate", int'(fetch_gate), int'(e_gate));
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_update();
    #1;
    compare();
  endtask

  task automatic idle();
    fe_valid = 0; fe_is_load = 0; rs_valid = 0; cm_valid = 0;
  endtask

  task automatic lookup(input logic [1:0] t, input logic [31:0] pc);
    fe_valid = 1; fe_is_load = 1; fe_tid = t; fe_pc = pc;
  endtask

  task automatic resolve(input logic [1:0] t, input logic [31:0] pc,
                         input logic miss, input logic fc);
    rs_valid = 1; rs_tid = t; rs_pc = pc; rs_miss = miss; rs_fe_counted = fc;
  endtask

  task automatic commit(input logic [1:0] t, input logic c);
    cm_valid = 1; cm_tid = t; cm_counted = c;
  endtask

  localparam logic [31:0] PA = 32'h0000_1000;
  localparam logic [31:0] PB = 32'h0000_2040;

  initial begin : watchdog
    #(150_000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) step();
    rst = 0;
    step();
    // R1: reset state
    chk("R1 gate after reset", int'(fetch_gate), 0);
    chk("R1 pred_vld after reset", int'(fe_pred_vld), 0);

    // R1: initial entry predicts hit
    lookup(0, PA); step(); idle();
    chk("R1 initial predicts hit", int'(fe_pred_miss), 0);

    // R7: uncounted miss counts at resolve
    resolve(0, PA, 1, 0); step(); idle();
    chk("R7 rs_counted", int'(rs_counted), 1);
    chk("R7 gate thread0", int'(fetch_gate[0]), 1);

    // R2: alias (bit 13 and bit 0 differ) sees cleared entry; R6 counts at fetch
    lookup(1, PA + 32'h2001); step(); idle();
    chk("R2 alias predicts miss", int'(fe_pred_miss), 1);
    chk("R6 counted at fetch", int'(fe_pred_counted), 1);
    chk("R6 gate thread1", int'(fetch_gate[1]), 1);

    // R9: counted commit decrements, uncounted commit does nothing
    commit(1, 1); step(); idle();
    chk("R9 counted commit", int'(fetch_gate[1]), 0);
    commit(0, 0); step(); idle();
    chk("R9 uncounted commit ignored", int'(fetch_gate[0]), 1);

    // R5: same-cycle train (hit) and lookup see old value 00
    lookup(2, PA); resolve(2, PA, 0, 0); step(); idle();
    chk("R5 lookup sees pre-update", int'(fe_pred_miss), 1);
    chk("R12 thread0 untouched", int'(fetch_gate[0]), 1);
    commit(2, 1); step(); idle();
    // R4: entry 01 -> hit -> 10, now predicts hit
    resolve(2, PA, 0, 0); step(); idle();
    lookup(2, PA); step(); idle();
    chk("R4 two hits restore hit", int'(fe_pred_miss), 0);
    chk("R4 no count", int'(fetch_gate[2]), 0);

    // R8: prediction off
    resolve(3, PB, 1, 0); step(); idle();
    commit(3, 1); step(); idle();
    pred_en = 0;
    lookup(3, PB); step(); idle();
    chk("R8 still predicts miss", int'(fe_pred_miss), 1);
    chk("R8 not counted", int'(fe_pred_counted), 0);
    chk("R8 gate low", int'(fetch_gate[3]), 0);
    resolve(3, PB, 1, 0); step(); idle();
    chk("R8 execute miss counted", int'(fetch_gate[3]), 1);

    // R11: inc and dec same thread same cycle nets to zero
    resolve(3, PB, 1, 0); commit(3, 1); step(); idle();
    chk("R11 net unchanged", int'(fetch_gate[3]), 1);
    commit(3, 1); step(); idle();
    chk("R11 drained", int'(fetch_gate[3]), 0);
    commit(0, 1); step(); idle();
    chk("R9 thread0 drained", int'(fetch_gate[0]), 0);
    pred_en = 1;

    // random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 700 == 350) pred_en = ~pred_en;
      fe_valid = $urandom_range(0, 1); fe_is_load = $urandom_range(0, 2) != 0;
      fe_tid = 2'($urandom_range(0, 3));
      fe_pc = {$urandom_range(0, 7) << 13} | (32'($urandom_range(0, 15)) << 2) | 32'($urandom_range(0, 3));
      rs_valid = $urandom_range(0, 1); rs_tid = 2'($urandom_range(0, 3));
      rs_pc = (32'($urandom_range(0, 15)) << 2);
      rs_miss = $urandom_range(0, 2) == 0; rs_fe_counted = $urandom_range(0, 1);
      cm_valid = $urandom_range(0, 3) != 0; cm_tid = 2'($urandom_range(0, 3));
      cm_counted = $urandom_range(0, 3) != 0;
      step();
    end
    idle();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule